// File: doc/BRIEF.md
# Outbound Address Translation Unit

This block maps CPU-side outbound addresses onto bus addresses and transaction kinds through a small number of programmable regions. Each region has a 64-bit base, a 32-bit inclusive limit (its upper half is shared with the base), a 64-bit target, a transaction type and an enable bit. Software reaches the regions through one shared register window. A viewport register selects the region that the window reads and writes.

On the translate side, an address is presented every cycle. One clock later the block returns a hit flag, the translated address, the transaction type and, for configuration-type regions, a requester routing identifier. The identifier holds the bus, device and function numbers taken from the target. Where regions overlap, the lowest index wins. An address that falls in no enabled region leaves the block unchanged.

Top module: `ob_xlate_unit`

## Requirements
- R1: After reset every region is disabled with all fields zero, the viewport reads 0, and every translation misses.
- R2: Window select codes on `cfg_sel`: 0 viewport, 1 control (bit 31 enable, bit 30 always reads 0), 2 type (bits 2:0), 3 limit, 4 base low, 5 base high, 6 target low, 7 target high. A write with `cfg_we` stores into the selected region. `cfg_rdata` returns that region's field combinationally.
- R3: The viewport holds the direction in bit 31 (1 inbound, 0 outbound) and the region index in bits 7:0. It reads back exactly those bits.
- R4: While the viewport says inbound, or its index is at least NREG, window writes change no region and window reads return 0.
- R5: An address hits region i when region i is enabled and base <= address <= {base high, limit}. Results appear on the outputs one clock after the address is sampled.
- R6: On a hit, the output address is target + (address - base), and the type output is the region's type.
- R7: When several enabled regions contain the address, the lowest index supplies the result.
- R8: On a miss, the hit flag is 0, the output address equals the input address, the type is 0 and the identifier is 0.
- R9: A hit in a region of type 4 or 5 (configuration type 0 or 1) drives the identifier with target low bits 31:16: bus 31:24, device 23:19, function 18:16. Any other type drives 0.
- R10: A disabled region never hits, even when its range contains the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_sel | input | 3 | Window register select |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| xl_addr_i | input | 64 | Address to translate |
| xl_hit_o | output | 1 | A region matched |
| xl_addr_o | output | 64 | Translated or passed-through address |
| xl_type_o | output | 3 | Transaction type of the matching region |
| xl_rid_o | output | 16 | Bus/device/function identifier for configuration regions |

## Verification
A corrupted base, limit or enable shows up on the outputs as a wrong hit flag or a shifted address. This happens one clock after an address crosses the faulty edge, so addresses placed on both sides of each boundary expose it at once. A wrong viewport decode shows up either as a readback mismatch or as a translation change after an inbound write. A wrong priority shows up only inside overlapping ranges, so the overlap cases are directed on purpose.

// File: rtl/ob_xlate_unit.sv
module ob_xlate_unit #(
  parameter int NREG = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [63:0] xl_addr_i,
  output logic        xl_hit_o,
  output logic [63:0] xl_addr_o,
  output logic [2:0]  xl_type_o,
  output logic [15:0] xl_rid_o
);
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [2:0] S_VIEW = 3'd0, S_CTRL = 3'd1, S_TYPE = 3'd2, S_LIM = 3'd3,
                         S_BLO = 3'd4, S_BHI = 3'd5, S_TLO = 3'd6, S_THI = 3'd7;

  logic             vp_dir;
  logic [7:0]       vp_idx;
  logic [NREG-1:0]  en_q;
  logic [2:0]       typ_q [NREG];
  logic [31:0]      bl_q  [NREG];
  logic [31:0]      bh_q  [NREG];
  logic [31:0]      lim_q [NREG];
  logic [31:0]      tl_q  [NREG];
  logic [31:0]      th_q  [NREG];

  logic [63:0] base_w [NREG];
  logic [63:0] top_w  [NREG];
  logic [NREG-1:0] match_w;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_rg
      assign base_w[g]  = {bh_q[g], bl_q[g]};
      assign top_w[g]   = {bh_q[g], lim_q[g]};
      assign match_w[g] = en_q[g] && (xl_addr_i >= base_w[g]) && (xl_addr_i <= top_w[g]);
    end
  endgenerate

  wire            win_ok = !vp_dir && (32'(vp_idx) < NREG);
  wire [IDXW-1:0] cur    = vp_idx[IDXW-1:0];

  always_comb begin
    cfg_rdata = '0;
    if (cfg_sel == S_VIEW) cfg_rdata = {vp_dir, 23'b0, vp_idx};
    else if (win_ok) begin
      case (cfg_sel)
        S_CTRL:  cfg_rdata = {en_q[cur], 31'b0};
        S_TYPE:  cfg_rdata = {29'b0, typ_q[cur]};
        S_LIM:   cfg_rdata = lim_q[cur];
        S_BLO:   cfg_rdata = bl_q[cur];
        S_BHI:   cfg_rdata = bh_q[cur];
        S_TLO:   cfg_rdata = tl_q[cur];
        S_THI:   cfg_rdata = th_q[cur];
        default: cfg_rdata = '0;
      endcase
    end
  end

  logic            hit_c;
  logic [IDXW-1:0] hsel_c;
  always_comb begin
    hit_c  = 1'b0;
    hsel_c = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (match_w[i]) begin
        hit_c  = 1'b1;
        hsel_c = IDXW'(i);
      end
    end
  end

  wire [2:0]  htyp_c  = typ_q[hsel_c];
  wire [63:0] taddr_c = hit_c ? ({th_q[hsel_c], tl_q[hsel_c]} + (xl_addr_i - base_w[hsel_c]))
                              : xl_addr_i;
  wire        iscfg_c = hit_c && (htyp_c == 3'd4 || htyp_c == 3'd5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vp_dir    <= 1'b0;
      vp_idx    <= '0;
      en_q      <= '0;
      for (int i = 0; i < NREG; i++) begin
        typ_q[i] <= '0; bl_q[i] <= '0; bh_q[i] <= '0;
        lim_q[i] <= '0; tl_q[i] <= '0; th_q[i] <= '0;
      end
      xl_hit_o  <= 1'b0;
      xl_addr_o <= '0;
      xl_type_o <= '0;
      xl_rid_o  <= '0;
    end else begin
      if (cfg_we) begin
        if (cfg_sel == S_VIEW) begin
          vp_dir <= cfg_wdata[31];
          vp_idx <= cfg_wdata[7:0];
        end else if (win_ok) begin
          case (cfg_sel)
            S_CTRL:  en_q[cur]  <= cfg_wdata[31];
            S_TYPE:  typ_q[cur] <= cfg_wdata[2:0];
            S_LIM:   lim_q[cur] <= cfg_wdata;
            S_BLO:   bl_q[cur]  <= cfg_wdata;
            S_BHI:   bh_q[cur]  <= cfg_wdata;
            S_TLO:   tl_q[cur]  <= cfg_wdata;
            S_THI:   th_q[cur]  <= cfg_wdata;
            default: ;
          endcase
        end
      end
      xl_hit_o  <= hit_c;
      xl_addr_o <= taddr_c;
      xl_type_o <= hit_c ? htyp_c : 3'd0;
      xl_rid_o  <= iscfg_c ? tl_q[hsel_c][31:16] : 16'd0;
    end
  end

  // R8
  miss_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (xl_hit_o || (xl_addr_o == $past(xl_addr_i) && xl_type_o == 3'd0 && xl_rid_o == 16'd0)));

  // R10
  none_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !xl_hit_o);

  // R9
  rid_noncfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_type_o != 3'd4 && xl_type_o != 3'd5) |-> xl_rid_o == 16'd0);

  // R3
  view_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == S_VIEW) |=> (vp_dir == $past(cfg_wdata[31]) && vp_idx == $past(cfg_wdata[7:0])));

  generate
    for (g = 0; g < NREG; g++) begin : g_chk
      // R4
      blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel != S_VIEW && !win_ok) |=>
          ($stable(en_q[g]) && $stable(typ_q[g]) && $stable(bl_q[g]) && $stable(bh_q[g]) &&
           $stable(lim_q[g]) && $stable(tl_q[g]) && $stable(th_q[g])));
    end
  endgenerate
endmodule

// File: tb/ob_xlate_unit_tb.sv
`timescale 1ns/1ps
module ob_xlate_unit_tb_top;
  localparam int NREG = 4;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [63:0] xl_addr_i = 0, xl_addr_o;
  logic xl_hit_o;
  logic [2:0] xl_type_o;
  logic [15:0] xl_rid_o;

  ob_xlate_unit #(.NREG(NREG)) dut_i (.*);

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [63:0] mb [NREG];
  logic [31:0] ml [NREG];
  logic [63:0] mt [NREG];
  logic [2:0]  mty [NREG];
  logic        men [NREG];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] s, input logic [31:0] exp);
    @(negedge clk);
    cfg_sel = s;
    #1;
    chk(req, {32'b0, cfg_rdata}, {32'b0, exp});
  endtask

  task automatic prog(input int r, input logic [2:0] ty, input logic en,
                      input logic [63:0] b, input logic [31:0] l, input logic [63:0] t);
    wr(3'd0, 32'(r));
    wr(3'd2, {29'b0, ty});
    wr(3'd4, b[31:0]);
    wr(3'd5, b[63:32]);
    wr(3'd3, l);
    wr(3'd6, t[31:0]);
    wr(3'd7, t[63:32]);
    wr(3'd1, {en, 31'b0});
    mb[r] = b; ml[r] = l; mt[r] = t; mty[r] = ty; men[r] = en;
  endtask

  task automatic model(input logic [63:0] a, output logic h, output logic [63:0] o,
                       output logic [2:0] ty, output logic [15:0] id);
    h = 0; o = a; ty = 0; id = 0;
    for (int i = 0; i < NREG; i++) begin
      if (!h && men[i] && a >= mb[i] && a <= {mb[i][63:32], ml[i]}) begin
        h = 1; o = mt[i] + (a - mb[i]); ty = mty[i];
        id = (ty == 3'd4 || ty == 3'd5) ? mt[i][31:16] : 16'd0;
      end
    end
  endtask

  task automatic xl(input string req, input logic [63:0] a);
    logic h; logic [63:0] o; logic [2:0] ty; logic [15:0] id;
    model(a, h, o, ty, id);
    @(negedge clk);
    xl_addr_i = a;
    @(negedge clk);
    chk({req, " hit"}, {63'b0, xl_hit_o}, {63'b0, h});
    chk({req, " addr"}, xl_addr_o, o);
    chk({req, " type"}, {61'b0, xl_type_o}, {61'b0, ty});
    chk({req, " rid"}, {48'b0, xl_rid_o}, {48'b0, id});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) begin
      mb[i] = 0; ml[i] = 0; mt[i] = 0; mty[i] = 0; men[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_chk("R1 view", 3'd0, 32'h0);
    rd_chk("R1 ctrl", 3'd1, 32'h0);
    rd_chk("R1 base", 3'd4, 32'h0);
    xl("R1 R8 miss after reset", 64'h0000_0000_0000_0000);
    xl("R8 miss", 64'h1234_5678_9abc_def0);

    // R2 R3 program and read back
    prog(0, 3'd0, 1, 64'h0000_0001_0000_0000, 32'h0000_FFFF, 64'h0000_0000_8000_0000);
    rd_chk("R3 view", 3'd0, 32'h0);
    rd_chk("R2 ctrl", 3'd1, 32'h8000_0000);
    wr(3'd1, 32'hC000_0000);
    rd_chk("R2 bit30 reads 0", 3'd1, 32'h8000_0000);
    rd_chk("R2 limit", 3'd3, 32'h0000_FFFF);
    rd_chk("R2 base hi", 3'd5, 32'h1);
    rd_chk("R2 target lo", 3'd6, 32'h8000_0000);

    // R5 R6 boundaries
    xl("R5 base", 64'h0000_0001_0000_0000);
    xl("R5 limit", 64'h0000_0001_0000_FFFF);
    xl("R5 below base", 64'h0000_0000_FFFF_FFFF);
    xl("R5 above limit", 64'h0000_0001_0001_0000);
    xl("R6 middle", 64'h0000_0001_0000_1234);

    // R7 R9 overlap with config region
    prog(1, 3'd4, 1, 64'h0000_0001_0000_8000, 32'h0001_FFFF, 64'h0000_0000_05A8_0000);
    rd_chk("R3 view idx1", 3'd0, 32'h1);
    rd_chk("R2 type", 3'd2, 32'h4);
    xl("R7 overlap low index wins", 64'h0000_0001_0000_9000);
    xl("R9 cfg0 id", 64'h0000_0001_0001_0004);
    prog(2, 3'd5, 1, 64'h0000_0002_0000_0000, 32'h0000_0FFF, 64'h0000_0000_FFFF_0000);
    xl("R9 cfg1 id", 64'h0000_0002_0000_0010);

    // R10 disabled region ignored
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    men[0] = 0;
    xl("R10 disabled region0", 64'h0000_0001_0000_9000);
    xl("R10 disabled only region", 64'h0000_0001_0000_0010);

    // R4 inbound viewport
    wr(3'd0, 32'h8000_0001);
    rd_chk("R3 inbound view", 3'd0, 32'h8000_0001);
    rd_chk("R4 inbound read zero", 3'd4, 32'h0);
    wr(3'd1, 32'h0);
    wr(3'd4, 32'hDEAD_0000);
    xl("R4 inbound write ignored", 64'h0000_0001_0001_0004);
    wr(3'd0, 32'h1);
    rd_chk("R4 region1 base intact", 3'd4, 32'h0000_8000);
    rd_chk("R4 region1 ctrl intact", 3'd1, 32'h8000_0000);

    // R4 index out of range
    wr(3'd0, 32'h0000_0009);
    rd_chk("R4 oob read zero", 3'd6, 32'h0);
    wr(3'd6, 32'h1111_1111);
    wr(3'd0, 32'h1);
    rd_chk("R4 oob write ignored", 3'd6, 32'h05A8_0000);

    // random traffic
    for (int it = 0; it < 400; it++) begin
      if (it % 10 == 0) begin
        int r;
        logic [63:0] b, t;
        logic [31:0] lo, sz;
        logic [2:0] ty;
        r  = int'($urandom % NREG);
        lo = $urandom & 32'h7FFF_0000;
        sz = ($urandom & 32'h0000_FFFF) + 1;
        b  = {30'b0, 2'($urandom), lo};
        t  = {$urandom, $urandom};
        case ($urandom % 4)
          0: ty = 3'd0;
          1: ty = 3'd2;
          2: ty = 3'd4;
          default: ty = 3'd5;
        endcase
        prog(r, ty, ($urandom % 4) != 0, b, lo + sz - 1, t);
      end
      begin
        int r;
        logic [63:0] a;
        r = int'($urandom % NREG);
        a = mb[r] + 64'(($urandom & 32'h0001_FFFF)) - 64'd16;
        xl("R5 R6 R7 R8 R9 random", a);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule